// File: doc/BRIEF.md
# Coarse-Grained Multithreading Issue Switcher

This block sits at the issue end of a core that runs several hardware threads but executes only one of them at a time. It keeps one program counter and one architectural register bank per thread. The selected thread issues one instruction every cycle. When that thread reports a long-latency stall, such as a load that misses every cache level, the block parks it. It then spends one cycle choosing another thread and resumes issue from that thread on the next cycle.

A parked thread is skipped until its memory fill is reported, and then it becomes selectable again. Changing threads only changes which program counter and which register bank are in use; no state is copied or saved. The fetch side takes `issue_valid`, `issue_tid` and `issue_pc`. The memory side reports misses and fills, each tagged with a thread ID. The datapath reaches the replicated register file through one write port and one read port, both addressed by thread ID and register index.

Top module: `cgmt_switcher`

## Requirements
- R1: During the first cycle after reset is released, all threads are ready and thread 0 issues at its boot PC, which is BOOT_BASE + t*BOOT_STRIDE for thread t.
- R2: While no stall hits the active thread, it issues on every cycle, and its PC advances by PC_STEP each cycle.
- R3: A miss tagged with the active thread, presented in a cycle where that thread issues, causes exactly one cycle with `issue_valid` low. The next cycle issues from the first ready thread found searching upward from the missing thread's ID, wrapping modulo THREADS.
- R4: A thread that has missed is never chosen for issue until a fill tagged with its ID has been presented.
- R5: A resumed thread restarts from the PC that follows its missing instruction (miss PC + PC_STEP).
- R6: If no thread is ready after a miss, `issue_valid` stays low. When a fill is presented in cycle f, issue resumes from the filled thread in cycle f+2.
- R7: A fill tagged with a thread that is not blocked has no effect and is not remembered. That thread blocks normally on its next miss.
- R8: A miss presented while no instruction issues, or tagged with a thread other than the issuing one, sets `miss_err` high in the following cycle and causes no switch. In every other case `miss_err` is low.
- R9: Register writes go to the bank and index given by (`rf_wr_tid`, `rf_wr_idx`) and are visible on the combinational read port from the next cycle. Banks never affect one another, and thread switches leave their contents untouched. All registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | TID_W | Thread that owns the issue slot |
| issue_pc | output | PC_W | Fetch PC of the issuing thread |
| miss_valid | input | 1 | Long-latency stall reported for the instruction issued this cycle |
| miss_tid | input | TID_W | Thread tag of the stall |
| fill_valid | input | 1 | Outstanding memory data returned |
| fill_tid | input | TID_W | Thread tag of the fill |
| miss_err | output | 1 | Previous cycle carried a miss that did not match the issuing thread |
| rf_wr_en | input | 1 | Register write enable |
| rf_wr_tid | input | TID_W | Bank select for the write |
| rf_wr_idx | input | IDX_W | Register index for the write |
| rf_wr_data | input | DATA_W | Write data |
| rf_rd_tid | input | TID_W | Bank select for the read |
| rf_rd_idx | input | IDX_W | Register index for the read |
| rf_rd_data | output | DATA_W | Read data (combinational) |

## Verification
The bench builds the block with its default parameters: four threads, sixteen 32-bit registers per bank, a PC step of 4 and a boot stride of 0x1000. Four threads are enough for the round-robin search to wrap past the top ID. With that count, random miss and fill traffic often drives every thread into the blocked state, so the starvation path, fill-while-ready events and misses during bubbles all occur many times. The distinct boot regions make a PC that ends up in the wrong thread visible immediately, and sixteen registers per bank let writes and reads to equal indices in different banks test bank isolation.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;

    // Scheduler phase of the issue slot
    typedef enum logic [1:0] {
        PH_ISSUE  = 2'd0,   // active thread owns the slot
        PH_SELECT = 2'd1,   // one-cycle bubble after a stall
        PH_STARVE = 2'd2    // every thread blocked, waiting for a fill
    } sched_phase_e;

    // Slot visited at distance 'off' from 'cur' in a ring of 'n' threads
    function automatic int ring_slot(input int cur, input int off, input int n);
        return (cur + off) % n;
    endfunction

endpackage

// File: rtl/cgmt_ready_tracker.sv
module cgmt_ready_tracker #(
    parameter int THREADS = 4,
    parameter int TID_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               block_en,
    input  logic [TID_W-1:0]   block_tid,
    input  logic               wake_en,
    input  logic [TID_W-1:0]   wake_tid,
    output logic [THREADS-1:0] ready
);

    for (genvar t = 0; t < THREADS; t++) begin : g_flag
        logic rdy_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                rdy_q <= 1'b1;
            end else if (block_en && block_tid == TID_W'(t)) begin
                rdy_q <= 1'b0;
            end else if (wake_en && wake_tid == TID_W'(t) && !rdy_q) begin
                rdy_q <= 1'b1;
            end
        end

        assign ready[t] = rdy_q;
    end

endmodule

// File: rtl/cgmt_rr_pick.sv
module cgmt_rr_pick #(
    parameter int THREADS = 4,
    parameter int TID_W   = 2
) (
    input  logic [THREADS-1:0] ready,
    input  logic [TID_W-1:0]   cur_tid,
    output logic               found,
    output logic [TID_W-1:0]   pick_tid
);
    import cgmt_pkg::*;

    always_comb begin
        found    = 1'b0;
        pick_tid = '0;
        for (int off = 1; off <= THREADS; off++) begin
            int slot;
            slot = ring_slot(int'(cur_tid), off, THREADS);
            if (!found && ready[slot]) begin
                found    = 1'b1;
                pick_tid = TID_W'(slot);
            end
        end
    end

endmodule

// File: rtl/cgmt_pc_bank.sv
module cgmt_pc_bank #(
    parameter int          THREADS     = 4,
    parameter int          TID_W       = 2,
    parameter int          PC_W        = 32,
    parameter int          PC_STEP     = 4,
    parameter int unsigned BOOT_BASE   = 0,
    parameter int unsigned BOOT_STRIDE = 32'h1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_en,
    input  logic [TID_W-1:0] adv_tid,
    input  logic [TID_W-1:0] rd_tid,
    output logic [PC_W-1:0]  rd_pc
);

    logic [PC_W-1:0] pc_vec [THREADS];

    for (genvar t = 0; t < THREADS; t++) begin : g_pc
        localparam logic [PC_W-1:0] BOOT_PC = PC_W'(BOOT_BASE + t * BOOT_STRIDE);
        logic [PC_W-1:0] pc_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pc_q <= BOOT_PC;
            end else if (adv_en && adv_tid == TID_W'(t)) begin
                pc_q <= pc_q + PC_W'(PC_STEP);
            end
        end

        assign pc_vec[t] = pc_q;
    end

    assign rd_pc = pc_vec[rd_tid];

endmodule

// File: rtl/cgmt_reg_bank.sv
module cgmt_reg_bank #(
    parameter int THREADS = 4,
    parameter int TID_W   = 2,
    parameter int REGS    = 16,
    parameter int IDX_W   = 4,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TID_W-1:0]  rd_tid,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] bank_out [THREADS];

    for (genvar t = 0; t < THREADS; t++) begin : g_bank
        logic [DATA_W-1:0] cells [REGS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int r = 0; r < REGS; r++) begin
                    cells[r] <= '0;
                end
            end else if (wr_en && wr_tid == TID_W'(t)) begin
                cells[wr_idx] <= wr_data;
            end
        end

        assign bank_out[t] = cells[rd_idx];
    end

    assign rd_data = bank_out[rd_tid];

endmodule

// File: rtl/cgmt_switcher.sv
module cgmt_switcher #(
    parameter int          THREADS     = 4,
    parameter int          PC_W        = 32,
    parameter int          PC_STEP     = 4,
    parameter int unsigned BOOT_BASE   = 0,
    parameter int unsigned BOOT_STRIDE = 32'h1000,
    parameter int          REGS        = 16,
    parameter int          DATA_W      = 32,
    localparam int         TID_W       = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int         IDX_W       = (REGS > 1) ? $clog2(REGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic              issue_valid,
    output logic [TID_W-1:0]  issue_tid,
    output logic [PC_W-1:0]   issue_pc,
    input  logic              miss_valid,
    input  logic [TID_W-1:0]  miss_tid,
    input  logic              fill_valid,
    input  logic [TID_W-1:0]  fill_tid,
    output logic              miss_err,
    input  logic              rf_wr_en,
    input  logic [TID_W-1:0]  rf_wr_tid,
    input  logic [IDX_W-1:0]  rf_wr_idx,
    input  logic [DATA_W-1:0] rf_wr_data,
    input  logic [TID_W-1:0]  rf_rd_tid,
    input  logic [IDX_W-1:0]  rf_rd_idx,
    output logic [DATA_W-1:0] rf_rd_data
);
    import cgmt_pkg::*;

    sched_phase_e        phase_q;
    logic [TID_W-1:0]    active_q;
    logic                err_q;
    logic [THREADS-1:0]  ready_vec;
    logic                pick_found;
    logic [TID_W-1:0]    pick_tid;
    logic                stall_hit;
    logic                slot_busy;

    assign slot_busy = (phase_q == PH_ISSUE);
    assign stall_hit = slot_busy && miss_valid && (miss_tid == active_q);

    cgmt_ready_tracker #(
        .THREADS (THREADS),
        .TID_W   (TID_W)
    ) u_ready (
        .clk       (clk),
        .rst       (rst),
        .block_en  (stall_hit),
        .block_tid (active_q),
        .wake_en   (fill_valid),
        .wake_tid  (fill_tid),
        .ready     (ready_vec)
    );

    cgmt_rr_pick #(
        .THREADS (THREADS),
        .TID_W   (TID_W)
    ) u_pick (
        .ready    (ready_vec),
        .cur_tid  (active_q),
        .found    (pick_found),
        .pick_tid (pick_tid)
    );

    cgmt_pc_bank #(
        .THREADS     (THREADS),
        .TID_W       (TID_W),
        .PC_W        (PC_W),
        .PC_STEP     (PC_STEP),
        .BOOT_BASE   (BOOT_BASE),
        .BOOT_STRIDE (BOOT_STRIDE)
    ) u_pcs (
        .clk     (clk),
        .rst     (rst),
        .adv_en  (slot_busy),
        .adv_tid (active_q),
        .rd_tid  (active_q),
        .rd_pc   (issue_pc)
    );

    cgmt_reg_bank #(
        .THREADS (THREADS),
        .TID_W   (TID_W),
        .REGS    (REGS),
        .IDX_W   (IDX_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rf_wr_en),
        .wr_tid  (rf_wr_tid),
        .wr_idx  (rf_wr_idx),
        .wr_data (rf_wr_data),
        .rd_tid  (rf_rd_tid),
        .rd_idx  (rf_rd_idx),
        .rd_data (rf_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_ISSUE;
            active_q <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= miss_valid && !stall_hit;
            unique case (phase_q)
                PH_ISSUE: begin
                    if (stall_hit) begin
                        phase_q <= PH_SELECT;
                    end
                end
                PH_SELECT, PH_STARVE: begin
                    if (pick_found) begin
                        active_q <= pick_tid;
                        phase_q  <= PH_ISSUE;
                    end else begin
                        phase_q  <= PH_STARVE;
                    end
                end
                default: phase_q <= PH_ISSUE;
            endcase
        end
    end

    assign issue_valid = slot_busy;
    assign issue_tid   = active_q;
    assign miss_err    = err_q;

endmodule

// File: rtl/cgmt_switcher_chk.sv
module cgmt_switcher_chk #(
    parameter int TID_W   = 2,
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             issue_valid,
    input logic [TID_W-1:0] issue_tid,
    input logic [PC_W-1:0]  issue_pc,
    input logic             miss_valid,
    input logic [TID_W-1:0] miss_tid,
    input logic             miss_err
);

    logic hit;
    assign hit = issue_valid && miss_valid && (miss_tid == issue_tid);

    // R1
    boot_thread_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (issue_valid && issue_tid == '0));

    // R2
    steady_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !hit) |=>
        (issue_valid && issue_tid == $past(issue_tid) &&
         issue_pc == $past(issue_pc) + PC_W'(PC_STEP)));

    // R3
    switch_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> !issue_valid);

    // R4
    no_self_resume_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(hit, 2) && issue_valid) |-> (issue_tid != $past(issue_tid, 2)));

    // R8
    stray_miss_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && !hit) |=> miss_err);

    // R8
    quiet_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !(miss_valid && !hit) |=> !miss_err);

endmodule

bind cgmt_switcher cgmt_switcher_chk #(
    .TID_W   (TID_W),
    .PC_W    (PC_W),
    .PC_STEP (PC_STEP)
) u_switcher_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_tid   (issue_tid),
    .issue_pc    (issue_pc),
    .miss_valid  (miss_valid),
    .miss_tid    (miss_tid),
    .miss_err    (miss_err)
);

// File: tb/test_cgmt_switcher.sv
module test_cgmt_switcher;

    localparam int NT     = 4;
    localparam int NR     = 16;
    localparam int STEP   = 4;
    localparam int STRIDE = 32'h1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid;
    logic [1:0]  issue_tid;
    logic [31:0] issue_pc;
    logic        miss_valid = 1'b0;
    logic [1:0]  miss_tid = '0;
    logic        fill_valid = 1'b0;
    logic [1:0]  fill_tid = '0;
    logic        miss_err;
    logic        rf_wr_en = 1'b0;
    logic [1:0]  rf_wr_tid = '0;
    logic [3:0]  rf_wr_idx = '0;
    logic [31:0] rf_wr_data = '0;
    logic [1:0]  rf_rd_tid = '0;
    logic [3:0]  rf_rd_idx = '0;
    logic [31:0] rf_rd_data;

    always #5 clk = ~clk;

    cgmt_switcher i_cgmt_switcher (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc),
        .miss_valid(miss_valid), .miss_tid(miss_tid),
        .fill_valid(fill_valid), .fill_tid(fill_tid),
        .miss_err(miss_err),
        .rf_wr_en(rf_wr_en), .rf_wr_tid(rf_wr_tid), .rf_wr_idx(rf_wr_idx),
        .rf_wr_data(rf_wr_data), .rf_rd_tid(rf_rd_tid), .rf_rd_idx(rf_rd_idx),
        .rf_rd_data(rf_rd_data)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model: 0 = issuing, 1 = bubble, 2 = starved
    int          m_st;
    int          m_act;
    logic [31:0] m_pc  [NT];
    bit          m_rdy [NT];
    bit          m_err;
    logic [31:0] m_reg [NT][NR];

    // Register port stimulus for the next cycle
    bit          d_we;
    int          d_wt, d_wi, d_rt, d_ri;
    logic [31:0] d_wd;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st  = 0;
        m_act = 0;
        m_err = 1'b0;
        for (int t = 0; t < NT; t++) begin
            m_pc[t]  = 32'(t * STRIDE);
            m_rdy[t] = 1'b1;
            for (int r = 0; r < NR; r++) m_reg[t][r] = '0;
        end
    endtask

    function automatic int m_pick();
        for (int off = 1; off <= NT; off++) begin
            if (m_rdy[(m_act + off) % NT]) return (m_act + off) % NT;
        end
        return -1;
    endfunction

    task automatic compare();
        chk(issue_valid === (m_st == 0), "R3/R6 issue_valid", longint'(issue_valid), longint'(m_st == 0));
        if (m_st == 0) begin
            chk(issue_tid === 2'(m_act), "R3 R4 issue_tid", longint'(issue_tid), longint'(m_act));
            chk(issue_pc === m_pc[m_act], "R2 R5 issue_pc", longint'(issue_pc), longint'(m_pc[m_act]));
        end
        chk(miss_err === m_err, "R8 miss_err", longint'(miss_err), longint'(m_err));
        chk(rf_rd_data === m_reg[rf_rd_tid][rf_rd_idx], "R9 rf_rd_data",
            longint'(rf_rd_data), longint'(m_reg[rf_rd_tid][rf_rd_idx]));
    endtask

    task automatic model_step(input bit mv, input int mt, input bit fv, input int ft);
        bit hit;
        bit wake;
        int p;
        hit  = (m_st == 0) && mv && (mt == m_act);
        wake = fv && !m_rdy[ft];
        p    = m_pick();
        m_err = mv && !hit;
        if (m_st == 0) begin
            m_pc[m_act] = m_pc[m_act] + STEP;
            if (hit) begin
                m_rdy[m_act] = 1'b0;
                m_st = 1;
            end
        end else if (p >= 0) begin
            m_act = p;
            m_st  = 0;
        end else begin
            m_st = 2;
        end
        if (wake) m_rdy[ft] = 1'b1;
        if (d_we) m_reg[d_wt][d_wi] = d_wd;
    endtask

    // One clock: compare, drive, advance model, move to next negedge
    task automatic cyc(input bit mv, input int mt, input bit fv, input int ft);
        compare();
        miss_valid = mv;
        miss_tid   = 2'(mt);
        fill_valid = fv;
        fill_tid   = 2'(ft);
        rf_wr_en   = d_we;
        rf_wr_tid  = 2'(d_wt);
        rf_wr_idx  = 4'(d_wi);
        rf_wr_data = d_wd;
        rf_rd_tid  = 2'(d_rt);
        rf_rd_idx  = 4'(d_ri);
        model_step(mv, mt, fv, ft);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(1'b0, 0, 1'b0, 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        d_we = 1'b0; d_wt = 0; d_wi = 0; d_wd = '0; d_rt = 0; d_ri = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: boot state
        chk(issue_valid === 1'b1 && issue_tid === 2'd0 && issue_pc === 32'h0,
            "R1 boot issue", longint'(issue_pc), 0);

        // R2: straight-line issue
        idle(); idle(); idle();

        // R7: fill for a thread that is still ready
        cyc(1'b0, 0, 1'b1, 2);

        // R3: miss on thread 0, bubble, then thread 1
        cyc(1'b1, m_act, 1'b0, 0);
        chk(issue_valid === 1'b0, "R3 bubble", longint'(issue_valid), 0);
        idle();
        chk(issue_tid === 2'd1, "R3 next thread", longint'(issue_tid), 1);

        // R8: miss tagged with a non-issuing thread, no switch
        cyc(1'b1, 3, 1'b0, 0);
        chk(miss_err === 1'b1 && issue_valid === 1'b1 && issue_tid === 2'd1,
            "R8 stray miss", longint'(miss_err), 1);

        // Block threads 1, 2 and 3 in turn
        cyc(1'b1, m_act, 1'b0, 0); idle();
        chk(issue_tid === 2'd2, "R3 R4 skip to thread 2", longint'(issue_tid), 2);
        cyc(1'b1, m_act, 1'b0, 0); idle();
        chk(issue_tid === 2'd3, "R3 thread 3", longint'(issue_tid), 3);
        cyc(1'b1, m_act, 1'b0, 0); idle(); idle();
        chk(issue_valid === 1'b0, "R6 R7 all blocked", longint'(issue_valid), 0);

        // R8: miss while starved
        cyc(1'b1, 1, 1'b0, 0);
        chk(miss_err === 1'b1, "R8 miss while starved", longint'(miss_err), 1);

        // R6 R5: fill thread 2, issue two cycles later from its saved PC
        cyc(1'b0, 0, 1'b1, 2);
        chk(issue_valid === 1'b0, "R6 still starved", longint'(issue_valid), 0);
        idle();
        chk(issue_valid === 1'b1 && issue_tid === 2'd2 && issue_pc === 32'h2004,
            "R5 R6 resume thread 2", longint'(issue_pc), 32'h2004);

        // R9: same index in two banks
        d_we = 1'b1; d_wt = 0; d_wi = 5; d_wd = 32'hA5A5_0000;
        idle();
        d_wt = 1; d_wd = 32'h0000_5A5A;
        idle();
        d_we = 1'b0; d_rt = 0; d_ri = 5;
        idle();
        chk(rf_rd_data === 32'hA5A5_0000, "R9 bank 0", longint'(rf_rd_data), 32'hA5A5_0000);
        d_rt = 1;
        idle();
        chk(rf_rd_data === 32'h0000_5A5A, "R9 bank 1", longint'(rf_rd_data), 32'h0000_5A5A);

        // Random traffic compared against the model every clock
        for (int n = 0; n < 4000; n++) begin
            bit mv;
            int mt;
            mv = (m_st == 0) ? ($urandom % 5 == 0) : ($urandom % 25 == 0);
            mt = ($urandom % 8 == 0) ? int'($urandom % NT) : m_act;
            d_we = ($urandom % 2 == 0);
            d_wt = $urandom % NT;
            d_wi = $urandom % NR;
            d_wd = $urandom;
            d_rt = $urandom % NT;
            d_ri = $urandom % NR;
            cyc(mv, mt, ($urandom % 4 == 0), int'($urandom % NT));
        end
        d_we = 1'b0;
        idle();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule